// File: doc/BRIEF.md
# Presence-Tagged Synchronization Memory

This block is a small word-addressed store in which every 32-bit data word is paired with a single presence flag, marking the word as full or empty, so each location holds 33 bits of state. The presence flags are not stored beside their data words. Instead, the flags of every group of four consecutive words sit together in one tag entry per line. The block is meant to let producer and consumer threads hand single words to each other without separate locks.

A requester presents an opcode, a word address and write data on a valid/ready request channel. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. The block never applies back-pressure once reset is released, so `req_ready` is low only while reset is held and on the first edge after it. Exactly one cycle after each accepted request, the block answers with a one-cycle pulse on either `rsp_done` or `rsp_trap`. The response has no handshake; the requester must take it in that cycle.

Plain loads and stores ignore the presence flag. The synchronizing opcodes test the flag and update it in the same access. When the flag is in the wrong state for the opcode, they report a trap and leave both the data and the flag unchanged. Handling the trap is left to the requester.

Top module: `fesm_top`

## Requirements
- R1: While `rst_n` is low, `req_ready`, `rsp_done` and `rsp_trap` are low. After reset every presence flag reads empty, and `req_ready` is high from the second rising edge after release.
- R2: LD (opcode 3'b000) returns the stored word with done and leaves the presence flag unchanged, whatever its state.
- R3: ST (3'b001) writes the data with done and leaves the presence flag unchanged. `rsp_rdata` is zero for every store.
- R4: LDT (3'b010) returns the word with done when the flag is full, and traps when it is empty.
- R5: LDET (3'b011) traps when the flag is empty. Otherwise it returns the word with done and sets the flag to empty.
- R6: STF (3'b100) always writes the data, sets the flag to full and answers done.
- R7: STFT (3'b101) traps when the flag is already full. Otherwise it writes the data, sets the flag to full and answers done.
- R8: A trapping access changes neither the data word nor any presence flag, and drives `rsp_rdata` to zero.
- R9: `rsp_done` and `rsp_trap` are never high together. Exactly one of them pulses for one cycle, in the cycle after each accepted request, and neither is high in any other cycle.
- R10: Each of the four words in a line has its own flag within the line's tag. Updating one flag leaves the other three flags of the line unchanged.
- R11: The unused opcodes 3'b110 and 3'b111 trap and change nothing.
- R12: Back-to-back requests on consecutive cycles are accepted without stalls, and each one observes the data and flags written by the request before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request on this edge |
| req_op | input | 3 | Opcode (see R2 to R7 and R11) |
| req_addr | input | ADDR_W (6) | Word address; the upper bits select the line, the lower two bits select the word within it |
| req_wdata | input | DATA_W (32) | Store data |
| rsp_rdata | output | DATA_W (32) | Load data. It is valid with `rsp_done` and is zero otherwise |
| rsp_done | output | 1 | Normal completion pulse |
| rsp_trap | output | 1 | Bad-condition pulse; the access had no effect |

## Verification
Every word address is driven through a fixed script of opcodes that moves its flag through empty, full, empty and full again. Each synchronizing opcode is therefore tried once with a matching flag, where it must complete, and once with a mismatched flag, where it must trap. The bench keeps its own model of the data and flags, so an access that wrongly touches a neighbouring word of the same line shows up later, when that word is accessed and returns a wrong flag or data. Requests are issued back to back, so each check also confirms that the previous request's write is visible at once. Idle cycles and the unused opcodes confirm that no response or update occurs without a valid request.

// File: rtl/fesm_pkg.sv
package fesm_pkg;
  localparam logic [2:0] OP_LD   = 3'b000;
  localparam logic [2:0] OP_ST   = 3'b001;
  localparam logic [2:0] OP_LDT  = 3'b010;
  localparam logic [2:0] OP_LDET = 3'b011;
  localparam logic [2:0] OP_STF  = 3'b100;
  localparam logic [2:0] OP_STFT = 3'b101;

  typedef struct packed {
    logic trap;     // bad condition, no side effects
    logic data_we;  // write data word
    logic tag_we;   // update presence flag
    logic tag_val;  // new presence value
    logic rd_en;    // return stored word
  } fesm_act_t;
endpackage

// File: rtl/fesm_decide.sv
module fesm_decide
  import fesm_pkg::*;
(
  input  logic [2:0] op,
  input  logic       present,
  output fesm_act_t  act
);
  always_comb begin
    act = '0;
    unique case (op)
      OP_LD:   act.rd_en = 1'b1;
      OP_ST:   act.data_we = 1'b1;
      OP_LDT:  begin
        act.trap  = ~present;
        act.rd_en = present;
      end
      OP_LDET: begin
        act.trap    = ~present;
        act.rd_en   = present;
        act.tag_we  = present;
        act.tag_val = 1'b0;
      end
      OP_STF:  begin
        act.data_we = 1'b1;
        act.tag_we  = 1'b1;
        act.tag_val = 1'b1;
      end
      OP_STFT: begin
        act.trap    = present;
        act.data_we = ~present;
        act.tag_we  = ~present;
        act.tag_val = 1'b1;
      end
      default: act.trap = 1'b1;
    endcase
  end
endmodule

// File: rtl/fesm_data_store.sv
module fesm_data_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/fesm_tag_store.sv
module fesm_tag_store #(
  parameter int ADDR_W = 6,
  parameter int WPL    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              wval,
  output logic              present
);
  localparam int OFF_W  = $clog2(WPL);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int LINES  = 2 ** LINE_W;

  logic [WPL-1:0]    tags [LINES];
  logic [LINE_W-1:0] line;
  logic [OFF_W-1:0]  off;

  assign line = addr[ADDR_W-1:OFF_W];
  assign off  = addr[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) tags[i] <= '0;
    end else if (we) begin
      tags[line][off] <= wval;
    end
  end

  assign present = tags[line][off];

  // R10: a flag update lands on the addressed word only
  assert_flag_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (tags[$past(line)][$past(off)] == $past(wval)));
  assert_line_others_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((tags[$past(line)] & ~(WPL'(1) << $past(off)))
            == ($past(tags[line]) & ~(WPL'(1) << $past(off)))));
endmodule

// File: rtl/fesm_top.sv
module fesm_top
  import fesm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int WPL    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              rsp_trap
);
  logic              accept;
  logic              present;
  logic [DATA_W-1:0] cur_word;
  fesm_act_t         act;

  assign accept = req_valid & req_ready;

  fesm_decide u_decide (
    .op      (req_op),
    .present (present),
    .act     (act)
  );

  fesm_data_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk   (clk),
    .addr  (req_addr),
    .we    (accept & act.data_we),
    .wdata (req_wdata),
    .rdata (cur_word)
  );

  fesm_tag_store #(.ADDR_W(ADDR_W), .WPL(WPL)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (req_addr),
    .we      (accept & act.tag_we),
    .wval    (act.tag_val),
    .present (present)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ready <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_trap  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      req_ready <= 1'b1;
      rsp_done  <= accept & ~act.trap;
      rsp_trap  <= accept & act.trap;
      rsp_rdata <= (accept & act.rd_en) ? cur_word : '0;
    end
  end

  // R9: single, exclusive response to each accepted request
  assert_done_trap_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && rsp_trap));
  assert_rsp_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done || rsp_trap) |-> $past(req_valid && req_ready));
  assert_req_gets_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_done || rsp_trap));
  // R8: trap carries no data
  assert_trap_zero_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trap |-> (rsp_rdata == '0));
  // R1: no acceptance or response while reset is held
  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (!req_ready && !rsp_done && !rsp_trap);
  end
endmodule

// File: tb/fesm_top_tb.sv
module fesm_top_tb;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int N  = 2 ** AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = 3'b000;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_done, rsp_trap;

  int vectors = 0;
  int fails   = 0;
  logic [DW-1:0] m_data [N];
  logic          m_full [N];

  always #2.5 clk = ~clk;

  fesm_top #(.ADDR_W(AW), .DATA_W(DW), .WPL(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_trap(rsp_trap)
  );

  task automatic check(input string tag, input logic [DW+1:0] act, input logic [DW+1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at negedge, then sample the response at the next negedge.
  task automatic access(input string tag, input logic [2:0] op, input int a, input logic [DW-1:0] wd);
    logic exp_trap;
    logic [DW-1:0] exp_rd;
    exp_trap = 1'b0;
    exp_rd   = '0;
    case (op)
      3'b000: exp_rd = m_data[a];
      3'b001: m_data[a] = wd;
      3'b010: if (!m_full[a]) exp_trap = 1'b1; else exp_rd = m_data[a];
      3'b011: if (!m_full[a]) exp_trap = 1'b1; else begin exp_rd = m_data[a]; m_full[a] = 1'b0; end
      3'b100: begin m_data[a] = wd; m_full[a] = 1'b1; end
      3'b101: if (m_full[a]) exp_trap = 1'b1; else begin m_data[a] = wd; m_full[a] = 1'b1; end
      default: exp_trap = 1'b1;
    endcase
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = AW'(a);
    req_wdata = wd;
    @(negedge clk);
    check(tag, {rsp_done, rsp_trap, rsp_rdata}, {~exp_trap, exp_trap, exp_rd});
  endtask

  task automatic idle_check();
    req_valid = 1'b0;
    req_op    = 3'b001;
    @(negedge clk);
    check("R9 idle", {rsp_done, rsp_trap, rsp_rdata}, '0);
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return (32'h9E37_79B9 * (a + 1)) ^ (32'h0101_0101 * k);
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_data[i] = '0; m_full[i] = 1'b0; end
    repeat (3) @(negedge clk);
    check("R1 reset", {req_ready, rsp_done, rsp_trap}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 ready", {req_ready, rsp_done, rsp_trap}, 3'b100);

    // R1: every flag empty after reset (LDT traps everywhere)
    for (int a = 0; a < N; a++) access("R1 empty", 3'b010, a, '0);
    idle_check();

    for (int a = 0; a < N; a++) begin
      access("R7 stft empty", 3'b101, a, pat(a, 1));
      access("R7 stft full", 3'b101, a, pat(a, 2));
      access("R8 unchanged", 3'b000, a, '0);
      access("R4 ldt full", 3'b010, a, '0);
      access("R5 ldet full", 3'b011, a, '0);
      access("R5 ldet empty", 3'b011, a, '0);
      access("R4 ldt empty", 3'b010, a, '0);
      access("R3 st", 3'b001, a, pat(a, 3));
      access("R2 ld empty", 3'b000, a, '0);
      access("R3 st kept", 3'b010, a, '0);
      access("R6 stf empty", 3'b100, a, pat(a, 4));
      access("R6 stf full", 3'b100, a, pat(a, 5));
      access("R11 op6", 3'b110, a, pat(a, 6));
      access("R11 op7", 3'b111, a, pat(a, 7));
      access("R2 ld full", 3'b000, a, '0);
      access("R12 b2b", 3'b010, a, '0);
    end
    idle_check();

    // R10: flip every other word of each line and check neighbours
    for (int a = 0; a < N; a += 2) access("R10 clear", 3'b011, a, '0);
    for (int a = 0; a < N; a++) access("R10 neighbours", 3'b010, a, '0);
    for (int a = 0; a < N; a++) access("R10 refill", 3'b101, a, pat(a, 8));
    idle_check();

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule